// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block is a register-mapped time-of-day keeper for a system that needs elapsed days, hours, minutes and seconds but no calendar. A separate prescaler supplies a single-cycle strobe once per second. While the run bit in the control register is set, each strobe advances the seconds counter. Seconds carry into minutes, minutes into hours, and hours into a free-running 16-bit day count.

A second set of registers holds an alarm instant. When a strobe moves the counters onto that instant, an alarm event is latched. Each strobe that advances the time also latches an update event. Software clears latched events by writing ones to them. An enable register selects which events drive the level interrupt output.

Software uses a 16-bit write strobe and a combinational read port, addressed by word index. Hours and minutes share one register, with the hour in the upper byte. The stopwatch event position exists in the status and enable layouts, but nothing raises it. Unused locations read as zero.

Top module: `rtc_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word map and fields:
  - Word 0 is time hour/minute, with the hour in bits [12:8] and the minute in bits [5:0]. Word 2 is the alarm hour/minute, with the same layout.
  - Word 1 is time seconds in bits [5:0]. Word 3 is alarm seconds, with the same layout.
  - Word 8 is the day count and word 9 is the alarm day, both 16 bits.
  - Word 4 is control, with the run bit at bit 7.
  - Word 5 is event status and word 6 is event enable. In both, the stopwatch event is bit 0, the alarm event is bit 2 and the update event is bit 4.
  - Written values are truncated to these fields, and all other bits read zero.
  - Words 7 and 10 to 15 read zero whatever is written to them.
- R3: Time advances by exactly one second per `tick_1hz` strobe while the run bit is 1. With the run bit at 0, or with no strobe, the time registers hold their values.
- R4: Seconds 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and increments the day. Day 0xFFFF wraps to 0.
- R5: A write to a time word in the same cycle as an advancing strobe loads the written value instead of the incremented one. A field that is loaded produces no carry in that cycle.
- R6: Status bit 2 is set when an advancing strobe, with no time word written in that cycle, makes day, hour, minute and second equal to the alarm words. Loading a time equal to the alarm does not set it. Once set, the bit stays set until it is cleared.
- R7: Every advancing strobe sets status bit 4.
- R8: Writing word 5 clears each status bit whose written bit is 1 and leaves the other bits unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly when some status bit and the matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 4 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_word` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives carries through every field boundary, including the day count wrapping past 0xFFFF. A design with a broken carry chain would show a stale minute or hour, or a day that never moves. It collides writes with strobes: on a wrong write priority, the loaded second would come back incremented, or the minute would step after a loaded 59. It collides clears with new events; a design that lets the clear win would drop the update event. Loading a time equal to the alarm catches a comparator that looks at the current value instead of the advanced one, since that design would raise the alarm without any strobe. Finally, the bench mixes enable masks with pending events: a wrong interrupt gate would raise `irq` for a masked event, or miss one that is enabled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W    = 16;
    localparam int WA_W      = 4;
    localparam int DAY_W     = 16;
    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int SEC_W     = $clog2(SEC_LAST + 1);
    localparam int MIN_W     = $clog2(MIN_LAST + 1);
    localparam int HOUR_W    = $clog2(HOUR_LAST + 1);
    localparam int HOUR_LSB  = DATA_W / 2;

    // word indices
    localparam logic [WA_W-1:0] REG_HM   = WA_W'(0);
    localparam logic [WA_W-1:0] REG_SEC  = WA_W'(1);
    localparam logic [WA_W-1:0] REG_AHM  = WA_W'(2);
    localparam logic [WA_W-1:0] REG_ASEC = WA_W'(3);
    localparam logic [WA_W-1:0] REG_CTRL = WA_W'(4);
    localparam logic [WA_W-1:0] REG_STAT = WA_W'(5);
    localparam logic [WA_W-1:0] REG_IEN  = WA_W'(6);
    localparam logic [WA_W-1:0] REG_DAY  = WA_W'(8);
    localparam logic [WA_W-1:0] REG_ADAY = WA_W'(9);

    // bit positions in the status, enable and control words
    localparam int BIT_SW   = 0;
    localparam int BIT_ALM  = 2;
    localparam int BIT_TICK = 4;
    localparam int BIT_RUN  = 7;

    // compact event vector
    localparam int EV_SW   = 0;
    localparam int EV_ALM  = 1;
    localparam int EV_TICK = 2;
    localparam int EV_N    = 3;
    localparam int EV_POS [EV_N] = '{BIT_SW, BIT_ALM, BIT_TICK};

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } tod_t;

    function automatic logic [DATA_W-1:0] hm_word(input logic [HOUR_W-1:0] h,
                                                  input logic [MIN_W-1:0] m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[HOUR_LSB +: HOUR_W] = h;
        w[MIN_W-1:0] = m;
        return w;
    endfunction
endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              ld_hm,
    input  logic              ld_sec,
    input  logic              ld_day,
    input  logic [DATA_W-1:0] wdata,
    output tod_t              cur,
    output tod_t              nxt
);
    tod_t t_d, t_q;
    logic c_sec, c_min, c_hour;

    always_comb begin
        t_d = t_q;
        c_sec = adv && !ld_sec && (t_q.sec >= SEC_W'(SEC_LAST));
        if (ld_sec)
            t_d.sec = wdata[SEC_W-1:0];
        else if (adv)
            t_d.sec = c_sec ? '0 : t_q.sec + 1'b1;

        c_min = c_sec && !ld_hm && (t_q.min >= MIN_W'(MIN_LAST));
        c_hour = c_min && (t_q.hour >= HOUR_W'(HOUR_LAST));
        if (ld_hm) begin
            t_d.min  = wdata[MIN_W-1:0];
            t_d.hour = wdata[HOUR_LSB +: HOUR_W];
        end else begin
            if (c_sec)
                t_d.min = c_min ? '0 : t_q.min + 1'b1;
            if (c_min)
                t_d.hour = c_hour ? '0 : t_q.hour + 1'b1;
        end

        if (ld_day)
            t_d.day = wdata[DAY_W-1:0];
        else if (c_hour)
            t_d.day = t_q.day + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cur = t_q;
    assign nxt = t_d;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ahm,
    input  logic              ld_asec,
    input  logic              ld_aday,
    input  logic [DATA_W-1:0] wdata,
    input  logic              arm,
    input  tod_t              cand,
    output tod_t              alm,
    output logic              hit
);
    tod_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (ld_asec)
            a_d.sec = wdata[SEC_W-1:0];
        if (ld_ahm) begin
            a_d.min  = wdata[MIN_W-1:0];
            a_d.hour = wdata[HOUR_LSB +: HOUR_W];
        end
        if (ld_aday)
            a_d.day = wdata[DAY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign alm = a_q;
    assign hit = arm && (cand == a_q);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] set_ev,
    input  logic [EV_N-1:0] clr_ev,
    input  logic            ld_en,
    input  logic [EV_N-1:0] en_in,
    output logic [EV_N-1:0] stat_ev,
    output logic [EV_N-1:0] ien_ev,
    output logic            irq
);
    typedef struct packed {
        logic [EV_N-1:0] stat;
        logic [EV_N-1:0] ien;
    } irq_st_t;

    irq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stat = (s_q.stat & ~clr_ev) | set_ev;
        if (ld_en)
            s_d.ien = en_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_ev = s_q.stat;
    assign ien_ev  = s_q.ien;
    assign irq     = |(s_q.stat & s_q.ien);
endmodule

// File: rtl/rtc_top.sv
module rtc_top
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [WA_W-1:0]   bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic run;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic ld_hm, ld_sec, ld_day, ld_ahm, ld_asec, ld_aday;
    logic wr_ctrl, wr_stat, wr_ien;
    logic adv, any_ld, alm_hit;
    tod_t cur, nxt, alm;
    logic [EV_N-1:0] wmask, set_ev, clr_ev, stat_ev, ien_ev;
    logic [DATA_W-1:0] stat_word, ien_word;

    assign ld_hm   = bus_wr && (bus_word == REG_HM);
    assign ld_sec  = bus_wr && (bus_word == REG_SEC);
    assign ld_day  = bus_wr && (bus_word == REG_DAY);
    assign ld_ahm  = bus_wr && (bus_word == REG_AHM);
    assign ld_asec = bus_wr && (bus_word == REG_ASEC);
    assign ld_aday = bus_wr && (bus_word == REG_ADAY);
    assign wr_ctrl = bus_wr && (bus_word == REG_CTRL);
    assign wr_stat = bus_wr && (bus_word == REG_STAT);
    assign wr_ien  = bus_wr && (bus_word == REG_IEN);

    always_comb begin
        c_d = c_q;
        if (wr_ctrl)
            c_d.run = bus_wdata[BIT_RUN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign adv    = tick_1hz && c_q.run;
    assign any_ld = ld_hm || ld_sec || ld_day;

    rtc_tod_counter u_tod (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .ld_hm  (ld_hm),
        .ld_sec (ld_sec),
        .ld_day (ld_day),
        .wdata  (bus_wdata),
        .cur    (cur),
        .nxt    (nxt)
    );

    rtc_alarm_cmp u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_ahm  (ld_ahm),
        .ld_asec (ld_asec),
        .ld_aday (ld_aday),
        .wdata   (bus_wdata),
        .arm     (adv && !any_ld),
        .cand    (nxt),
        .alm     (alm),
        .hit     (alm_hit)
    );

    // map event vector to and from its word positions
    always_comb begin
        stat_word = '0;
        ien_word  = '0;
        for (int e = 0; e < EV_N; e++) begin
            stat_word[EV_POS[e]] = stat_ev[e];
            ien_word[EV_POS[e]]  = ien_ev[e];
        end
    end

    for (genvar e = 0; e < EV_N; e++) begin : g_mask
        assign wmask[e] = bus_wdata[EV_POS[e]];
    end

    assign clr_ev = wr_stat ? wmask : '0;

    always_comb begin
        set_ev = '0;
        set_ev[EV_ALM]  = alm_hit;
        set_ev[EV_TICK] = adv;
    end

    rtc_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .clr_ev  (clr_ev),
        .ld_en   (wr_ien),
        .en_in   (wmask),
        .stat_ev (stat_ev),
        .ien_ev  (ien_ev),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_word)
            REG_HM:   bus_rdata = hm_word(cur.hour, cur.min);
            REG_SEC:  bus_rdata = DATA_W'(cur.sec);
            REG_AHM:  bus_rdata = hm_word(alm.hour, alm.min);
            REG_ASEC: bus_rdata = DATA_W'(alm.sec);
            REG_CTRL: bus_rdata[BIT_RUN] = c_q.run;
            REG_STAT: bus_rdata = stat_word;
            REG_IEN:  bus_rdata = ien_word;
            REG_DAY:  bus_rdata = DATA_W'(cur.day);
            REG_ADAY: bus_rdata = DATA_W'(alm.day);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             ld_sec,
    input logic [SEC_W-1:0] sec_now,
    input logic [SEC_W-1:0] wsec,
    input logic [EV_N-1:0]  clr_ev,
    input logic [EV_N-1:0]  stat_ev,
    input logic [EV_N-1:0]  ien_ev,
    input logic             irq
);
    assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_sec && sec_now < SEC_W'(SEC_LAST)) |=> (sec_now == $past(sec_now) + 1'b1));

    assert_sec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld_sec) |=> $stable(sec_now));

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_sec && sec_now == SEC_W'(SEC_LAST)) |=> (sec_now == '0));

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sec |=> (sec_now == $past(wsec)));

    assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ev[EV_ALM] && !clr_ev[EV_ALM]) |=> stat_ev[EV_ALM]);

    assert_tick_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> stat_ev[EV_TICK]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev[EV_TICK] && !adv) |=> !stat_ev[EV_TICK]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_ev == '0) |-> !irq);

    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ev == '0) |-> !irq);
endmodule

bind rtc_top rtc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .ld_sec  (ld_sec),
    .sec_now (cur.sec),
    .wsec    (bus_wdata[rtc_pkg::SEC_W-1:0]),
    .clr_ev  (clr_ev),
    .stat_ev (stat_ev),
    .ien_ev  (ien_ev),
    .irq     (irq)
);

// File: tb/tb_rtc_top.sv
module tb_rtc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rtc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    // {is_write, word, data, expected read}
    localparam int NV = 26;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 4'd0,  16'h0A1B, 16'h0000},
        {1'b0, 4'd0,  16'h0000, 16'h0A1B},
        {1'b1, 4'd0,  16'hFFFF, 16'h0000},
        {1'b0, 4'd0,  16'h0000, 16'h1F3F},
        {1'b1, 4'd1,  16'hFFE5, 16'h0000},
        {1'b0, 4'd1,  16'h0000, 16'h0025},
        {1'b1, 4'd2,  16'h1731, 16'h0000},
        {1'b0, 4'd2,  16'h0000, 16'h1731},
        {1'b1, 4'd3,  16'h003B, 16'h0000},
        {1'b0, 4'd3,  16'h0000, 16'h003B},
        {1'b1, 4'd8,  16'h1234, 16'h0000},
        {1'b0, 4'd8,  16'h0000, 16'h1234},
        {1'b1, 4'd9,  16'hBEEF, 16'h0000},
        {1'b0, 4'd9,  16'h0000, 16'hBEEF},
        {1'b1, 4'd4,  16'h00FF, 16'h0000},
        {1'b0, 4'd4,  16'h0000, 16'h0080},
        {1'b1, 4'd6,  16'hFFFF, 16'h0000},
        {1'b0, 4'd6,  16'h0000, 16'h0015},
        {1'b1, 4'd7,  16'hFFFF, 16'h0000},
        {1'b0, 4'd7,  16'h0000, 16'h0000},
        {1'b1, 4'd10, 16'hFFFF, 16'h0000},
        {1'b0, 4'd10, 16'h0000, 16'h0000},
        {1'b0, 4'd12, 16'h0000, 16'h0000},
        {1'b0, 4'd15, 16'h0000, 16'h0000},
        {1'b1, 4'd6,  16'h0000, 16'h0000},
        {1'b0, 4'd6,  16'h0000, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        tick_1hz = t; bus_wr = w; bus_word = a; bus_wdata = d;
        @(negedge clk);
        tick_1hz = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic tick();
        cyc(1'b1, 1'b0, 4'd0, 16'h0000);
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
        bus_word = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #2;
        chk(tag, {15'd0, irq}, {15'd0, exp});
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 hm", 4'd0, 16'h0000);
        rd("R1 sec", 4'd1, 16'h0000);
        rd("R1 ctrl", 4'd4, 16'h0000);
        rd("R1 stat", 4'd5, 16'h0000);
        rd("R1 ien", 4'd6, 16'h0000);
        rd("R1 day", 4'd8, 16'h0000);
        rd("R1 aday", 4'd9, 16'h0000);
        chk_irq("R1 irq", 1'b0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36])
                wr(VEC[i][35:32], VEC[i][31:16]);
            else
                rd($sformatf("R2 row %0d", i), VEC[i][35:32], VEC[i][15:0]);
        end

        // R3 run gating
        wr(4'd4, 16'h0000);
        wr(4'd1, 16'd5);
        tick();
        rd("R3 stopped sec", 4'd1, 16'd5);
        rd("R3 stopped no event", 4'd5, 16'h0000);
        wr(4'd4, 16'h0080);
        tick();
        rd("R3 one step", 4'd1, 16'd6);
        repeat (3) @(negedge clk);
        rd("R3 hold without tick", 4'd1, 16'd6);

        // R4 rollover chain
        wr(4'd5, 16'hFFFF);
        wr(4'd8, 16'd5); wr(4'd0, 16'h173B); wr(4'd1, 16'd59);
        tick();
        rd("R4 full sec", 4'd1, 16'd0);
        rd("R4 full hm", 4'd0, 16'h0000);
        rd("R4 full day", 4'd8, 16'd6);
        wr(4'd0, 16'h0A3B); wr(4'd1, 16'd59);
        tick();
        rd("R4 min carry hm", 4'd0, 16'h0B00);
        rd("R4 min carry day", 4'd8, 16'd6);
        wr(4'd1, 16'd30);
        tick();
        rd("R4 plain sec", 4'd1, 16'd31);
        rd("R4 plain hm", 4'd0, 16'h0B00);
        wr(4'd8, 16'hFFFF); wr(4'd0, 16'h173B); wr(4'd1, 16'd59);
        tick();
        rd("R4 day wrap", 4'd8, 16'h0000);
        rd("R4 day wrap hm", 4'd0, 16'h0000);

        // R7 update event
        wr(4'd5, 16'hFFFF);
        rd("R7 cleared", 4'd5, 16'h0000);
        tick();
        rd("R7 tick event", 4'd5, 16'h0010);

        // R8 write-one-to-clear
        wr(4'd5, 16'h0004);
        rd("R8 other bit kept", 4'd5, 16'h0010);
        wr(4'd5, 16'h0010);
        rd("R8 bit cleared", 4'd5, 16'h0000);
        cyc(1'b1, 1'b1, 4'd5, 16'h0010);
        rd("R8 set beats clear", 4'd5, 16'h0010);

        // R6 alarm match
        wr(4'd5, 16'hFFFF);
        wr(4'd9, 16'd3); wr(4'd2, 16'h0102); wr(4'd3, 16'd5);
        wr(4'd8, 16'd3); wr(4'd0, 16'h0102); wr(4'd1, 16'd4);
        tick();
        rd("R6 alarm set", 4'd5, 16'h0014);
        wr(4'd5, 16'h0010);
        rd("R6 alarm kept", 4'd5, 16'h0004);
        tick();
        rd("R6 sticky after pass", 4'd5, 16'h0014);
        wr(4'd5, 16'hFFFF);
        wr(4'd1, 16'd5);
        @(negedge clk);
        rd("R6 load no alarm", 4'd5, 16'h0000);

        // R9 interrupt gating
        wr(4'd6, 16'h0015);
        chk_irq("R9 nothing pending", 1'b0);
        tick();
        chk_irq("R9 tick enabled", 1'b1);
        wr(4'd6, 16'h0004);
        chk_irq("R9 tick masked", 1'b0);
        wr(4'd1, 16'd4);
        tick();
        chk_irq("R9 alarm enabled", 1'b1);
        wr(4'd5, 16'hFFFF);
        chk_irq("R9 cleared", 1'b0);
        wr(4'd6, 16'h0000);

        // R5 write priority over increment
        wr(4'd1, 16'd20);
        cyc(1'b1, 1'b1, 4'd1, 16'd10);
        rd("R5 sec load wins", 4'd1, 16'd10);
        wr(4'd0, 16'h0203); wr(4'd1, 16'd59);
        cyc(1'b1, 1'b1, 4'd1, 16'd7);
        rd("R5 loaded sec", 4'd1, 16'd7);
        rd("R5 no carry", 4'd0, 16'h0203);
        wr(4'd1, 16'd59);
        cyc(1'b1, 1'b1, 4'd0, 16'h0505);
        rd("R5 hm load wins", 4'd0, 16'h0505);
        rd("R5 sec still wraps", 4'd1, 16'd0);
        wr(4'd0, 16'h173B); wr(4'd1, 16'd59); wr(4'd8, 16'h0040);
        cyc(1'b1, 1'b1, 4'd8, 16'h0100);
        rd("R5 day load wins", 4'd8, 16'h0100);
        rd("R5 hm wrapped", 4'd0, 16'h0000);

        done = 1;
        summary();
    end
endmodule